// File: doc/BRIEF.md
# Random Word Peripheral Register Block

This block is a memory-mapped wrapper around a source of random 32-bit words. Once software turns it on with a key-protected control write, it captures a fresh word from the source at a fixed interval. It places the word in a read-only output register and raises a data-ready status flag. Software either polls that flag or lets it drive a single level-sensitive interrupt line through a mask bit. The mask bit is set and cleared through two separate write-one registers.

The physical entropy source is outside the block. A parameter selects one of two word sources. The first is a 32-bit input port, which a test environment or a real noise source drives. The second is an internal Galois LFSR that steps every cycle, with the input port XORed into its state. The bus is a plain single-cycle register port. Read data is combinational from the address while the read strobe is high. Every register update takes effect at the next rising clock edge.

Top module: `rng_regs`

## Requirements
- R1: After reset the generator is off, and the mask, the status flag and the output word are all 0. The interrupt line is low, and every register reads as 0.
- R2: A write to offset 0x00 changes the enable bit to write-data bit 0 only when write-data bits 31:8 equal 0x524E47. Any other value in those bits leaves the enable unchanged. Reading offset 0x00 returns the enable in bit 0.
- R3: While enabled, the word presented by the source is loaded into the output register (offset 0x50) at every 84th rising edge. The first load comes at the 84th edge after the edge that set the enable. The interval count restarts from zero after every off-to-on change, and no load happens while the block is off.
- R4: Each load sets status bit 0 (data ready), which is read at offset 0x1C.
- R5: A read of offset 0x1C clears the data-ready bit at the next edge. When a load falls on the same edge, the read returns the old value and the bit stays set.
- R6: Writing 1 in bit 0 at offset 0x10 sets the mask bit, and writing 1 in bit 0 at offset 0x14 clears it. A 0 in bit 0 of either write changes nothing. Offset 0x18 reads the mask in bit 0.
- R7: The interrupt output is high exactly when both the data-ready bit and the mask bit are 1.
- R8: Reading offset 0x50 leaves the status bit alone. Writes to 0x18, 0x1C, 0x50 and unmapped offsets change nothing. Unmapped offsets read as 0, and the read bus is 0 whenever no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| ext_entropy | input | 32 | External word source, or mixing input for the internal LFSR |
| irq | output | 1 | Data-ready interrupt, level |

## Verification
Read data is due in the same cycle as the read strobe. The bench therefore samples it one time unit after driving the inputs at the falling edge, before the rising edge that applies any side effect. Enable, mask and status changes from a write or read appear one edge later. The output word and the ready flag appear at the 84th edge after enabling. The interrupt follows the registered flags with no further delay. A bench reference model advances at each rising edge by the same counts, so every compare lands in the cycle where the requirement places the result. Directed steps probe the 83rd and 84th cycles and the read colliding with a load.

// File: rtl/rng_regs.sv
module rng_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PERIOD = 84,
  parameter logic [DATA_W-9:0] KEY = 24'h524E47,
  parameter bit EXT_SOURCE = 1'b0,
  parameter logic [DATA_W-1:0] LFSR_SEED = 32'hACE1_2468,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] ext_entropy,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'('h50);

  logic              en;
  logic              st;
  logic              mask;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] word;
  logic              load;
  logic              key_ok;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[7:1];
  assign key_ok = bus_wdata[DATA_W-1:8] == KEY;
  assign load   = en && (cnt == CNT_LAST);
  assign irq    = st & mask;

  generate
    if (EXT_SOURCE) begin : g_ext
      assign word = ext_entropy;
    end else begin : g_lfsr
      logic [DATA_W-1:0] lfsr;
      logic [DATA_W-1:0] lfsr_nx;
      assign lfsr_nx = lfsr[0] ? ((lfsr >> 1) ^ LFSR_TAPS) : (lfsr >> 1);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) lfsr <= LFSR_SEED;
        else        lfsr <= lfsr_nx ^ ext_entropy;
      assign word = lfsr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                     en <= 1'b0;
    else if (bus_we && bus_addr == A_CTRL && key_ok) en <= bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (!en || load) cnt <= '0;
    else                  cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              st <= 1'b0;
    else if (load)                           st <= 1'b1;
    else if (bus_re && bus_addr == A_STAT)   st <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                          mask <= 1'b0;
    else if (bus_we && bus_addr == A_MSET && bus_wdata[0]) mask <= 1'b1;
    else if (bus_we && bus_addr == A_MCLR && bus_wdata[0]) mask <= 1'b0;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_CTRL:  bus_rdata[0] = en;
        A_MASK:  bus_rdata[0] = mask;
        A_STAT:  bus_rdata[0] = st;
        A_WORD:  bus_rdata    = data_q;
        default: bus_rdata    = '0;
      endcase
    end
  end

endmodule

// File: rtl/rng_regs_chk.sv
module rng_regs_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-9:0] KEY = 24'h524E47
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-9:0] wkey,
  input logic              wbit0,
  input logic              irq,
  input logic              en,
  input logic              load,
  input logic              st,
  input logic              mask,
  input logic [DATA_W-1:0] data_q
);

  localparam logic [ADDR_W-1:0] C_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] C_MSET = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] C_MCLR = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'('h1C);

  AST_BADKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_CTRL && wkey != KEY) |=> $stable(en)); // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(data_q)); // R3
  AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> st); // R4
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == C_STAT && !load) |=> !st); // R5
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_MSET && wbit0) |=> mask); // R6
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_MCLR && wbit0) |=> !mask); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask || !st) |-> !irq); // R7

endmodule

bind rng_regs rng_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .wkey(bus_wdata[DATA_W-1:8]), .wbit0(bus_wdata[0]), .irq(irq), .en(en),
  .load(load), .st(st), .mask(mask), .data_q(data_q)
);

// File: tb/sim_rng_regs.sv
module sim_rng_regs;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 84;
  localparam logic [23:0] KEYV = 24'h524E47;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] ext_entropy = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;

  logic        m_en = 0, m_st = 0, m_mask = 0;
  int          m_cnt = 0;
  logic [31:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_regs #(.EXT_SOURCE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ext_entropy(ext_entropy), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'd0, m_en};
      8'h18: return {31'd0, m_mask};
      8'h1C: return {31'd0, m_st};
      8'h50: return m_data;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] wd,
                      input logic re, input logic [31:0] src, input string tag);
    logic ld;
    logic n_en;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd; bus_re = re; ext_entropy = src;
    #1;
    check("R7 irq", {31'd0, irq}, {31'd0, m_st & m_mask});
    if (re) check(tag, bus_rdata, exp_read(a));
    else    check("R8 idle bus", bus_rdata, 32'd0);
    @(posedge clk);
    ld = m_en && (m_cnt == PER - 1);
    n_en = m_en;
    if (we && a == 8'h00 && wd[31:8] == KEYV) n_en = wd[0];
    if (ld) m_data = src;
    if (ld) m_st = 1'b1;
    else if (re && a == 8'h1C) m_st = 1'b0;
    if (we && a == 8'h10 && wd[0]) m_mask = 1'b1;
    else if (we && a == 8'h14 && wd[0]) m_mask = 1'b0;
    m_cnt = (!m_en || ld) ? 0 : m_cnt + 1;
    m_en = n_en;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h04, 1'b0, 32'd0, 1'b0, $urandom, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] addrs [8];
    void'($urandom(32'd2024));
    addrs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h50, 8'h24, 8'hFC};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    step(8'h00, 0, 0, 1, 0, "R1 ctrl");
    step(8'h18, 0, 0, 1, 0, "R1 mask");
    step(8'h1C, 0, 0, 1, 0, "R1 stat");
    step(8'h50, 0, 0, 1, 0, "R1 word");

    // R2 wrong key then right key
    step(8'h00, 1, 32'h524E4601, 0, 0, "R2");
    step(8'h00, 0, 0, 1, 0, "R2 badkey");
    check("R2 literal", bus_rdata, 32'd0);
    step(8'h00, 1, {KEYV, 8'h01}, 0, 0, "R2");
    // R3 first load on 84th edge: 83 cycles pass with no flag
    for (int i = 0; i < 82; i++) step(8'h04, 0, 0, 0, 32'h1111_0000, "R3");
    step(8'h1C, 0, 0, 1, 32'h2222_0000, "R3 no flag at 83");
    check("R3 literal", bus_rdata, 32'd0);
    // R5 collision: read on loading edge returns 0, bit stays set
    step(8'h1C, 0, 0, 1, 32'hDEAD_BEEF, "R5 collide");
    check("R5 literal old", bus_rdata, 32'd0);
    step(8'h50, 0, 0, 1, 0, "R3 word");
    check("R3 literal word", bus_rdata, 32'hDEAD_BEEF);
    step(8'h1C, 0, 0, 1, 0, "R5 still set");
    check("R8 literal data read keeps flag", bus_rdata, 32'd1);
    step(8'h1C, 0, 0, 1, 0, "R5 cleared");
    check("R5 literal cleared", bus_rdata, 32'd0);

    // R6 zero writes no effect, then set/clear
    step(8'h10, 1, 32'hFFFF_FFFE, 0, 0, "R6");
    step(8'h18, 0, 0, 1, 0, "R6 zero set");
    step(8'h10, 1, 32'd1, 0, 0, "R6");
    step(8'h14, 1, 32'hFFFF_FFFE, 0, 0, "R6");
    step(8'h18, 0, 0, 1, 0, "R6 mask set");
    check("R6 literal", bus_rdata, 32'd1);
    // R8 writes to read-only and unmapped offsets
    step(8'h18, 1, 32'd0, 0, 0, "R8");
    step(8'h1C, 1, 32'd1, 0, 0, "R8");
    step(8'h50, 1, 32'hFFFF_FFFF, 0, 0, "R8");
    step(8'h44, 1, 32'hFFFF_FFFF, 1, 0, "R8 unmapped");
    // R4 R7 wait for next load with mask on
    idle(PER);
    step(8'h18, 0, 0, 1, 0, "R8 mask intact");
    step(8'h1C, 0, 0, 1, 0, "R4 flag");
    // R3 restart: disable then enable
    step(8'h00, 1, {KEYV, 8'h00}, 0, 0, "R3");
    idle(200);
    step(8'h00, 1, {KEYV, 8'h01}, 0, 0, "R3");
    idle(30);
    step(8'h00, 1, {KEYV, 8'h00}, 0, 0, "R3");
    step(8'h00, 1, {KEYV, 8'h01}, 0, 0, "R3");
    idle(90);
    step(8'h50, 0, 0, 1, 0, "R3 restart word");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] a;
      logic [31:0] wd;
      int op;
      op = $urandom_range(0, 9);
      a = addrs[$urandom_range(0, 7)];
      wd = $urandom;
      if (a == 8'h00 && $urandom_range(0, 1) == 1) wd[31:8] = KEYV;
      if (a == 8'h00 && $urandom_range(0, 7) != 0) wd[0] = 1'b1;
      if (op < 3)      step(a, 1, wd, 0, $urandom, "R2/R6/R8 random write");
      else if (op < 7) step(a, 0, 0, 1, $urandom, "R3/R4/R5 random read");
      else             step(a, 0, 0, 0, $urandom, "R8 random idle");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule